// File: doc/BRIEF.md
# Cascaded Eight-Channel DMA Request Router

This block joins two four-channel DMA controllers into one eight-channel system. The secondary controller serves system channels 0 to 3. Its bus-hold request enters local channel 0 of the primary controller. That makes system channel 4 a fixed cascade slot, and it leaves system channels 5 to 7 on primary local channels 1 to 3. Peripheral request lines pass through the router to the right controller and local channel. Acknowledges come back along the same path. A low channel is acknowledged only while the primary controller grants the cascade slot.

Software-side setup arrives as a one-cycle configuration write that carries a system channel number and a byte count. The router checks the write against the channel's width rules. Channels 0 to 3 move bytes. Channels 5 to 7 move 16-bit words, so a 16-bit bus-cycle count reaches twice as many bytes on them. A write that passes the checks produces a programming strobe for the owning controller, with the local channel, the cycle count minus one and the address step, and it enables request forwarding for that channel. A write that fails sets an error flag instead.

Top module: `dmaCascadeRouter`

## Requirements
- R1: A configuration write aimed at system channel 4 is rejected: one cycle later cfgErr is 1, progWr is 0, and the enable state of every channel is unchanged. A request on sysReq[4] is never forwarded, and sysAck[4] is always 0.
- R2: An accepted write to channels 0 to 3 gives, one cycle later, progWr=1, progCtrl=0 (secondary), progLocal equal to the channel number, progCount equal to bytes-1 and progStep=1. It also enables that channel.
- R3: An accepted write to channels 5 to 7 gives, one cycle later, progWr=1, progCtrl=1 (primary), progLocal equal to the channel number minus 4, progCount equal to bytes/2-1 and progStep=2. It also enables that channel.
- R4: An odd byte count on channels 5 to 7 is rejected: cfgErr=1, progWr=0, and the channel is left disabled.
- R5: A byte count of zero is rejected. A count above 65536 on channels 0 to 3, or above 131072 on channels 5 to 7, is also rejected. The maximum counts are accepted with progCount=16'hFFFF.
- R6: With no delay, secDreq[k] equals sysReq[k] for each enabled channel k of 0 to 3, and priDreq[k] equals sysReq[4+k] for each enabled channel 4+k of 5 to 7. A disabled channel forwards 0.
- R7: priDreq[0] follows secHoldReq, and secHoldAck follows priDack[0].
- R8: sysAck[k] for k of 0 to 3 is 1 only when secDack[k] is 1, priDack[0] is 1 and channel k is enabled.
- R9: sysAck[4+k] for k of 1 to 3 equals priDack[k] while that channel is enabled.
- R10: During and after reset, all channels are disabled, cfgErr=0 and progWr=0.
- R11: cfgErr changes only on a configuration write. An accepted write clears it, and it holds its value while cfgWr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | One-cycle configuration write strobe |
| cfgChan | input | 3 | System channel being configured |
| cfgBytes | input | 18 | Transfer length in bytes |
| progWr | output | 1 | Programming strobe to the selected controller |
| progCtrl | output | 1 | Target controller: 0 secondary, 1 primary |
| progLocal | output | 2 | Local channel inside the target controller |
| progCount | output | 16 | Bus cycles minus one |
| progStep | output | 2 | Address increment per bus cycle |
| cfgErr | output | 1 | Last configuration write was rejected |
| sysReq | input | 8 | Peripheral request per system channel |
| sysAck | output | 8 | Acknowledge per system channel |
| secDreq | output | 4 | Requests to the secondary controller |
| secDack | input | 4 | Acknowledges from the secondary controller |
| secHoldReq | input | 1 | Bus request from the secondary controller |
| secHoldAck | output | 1 | Bus grant back to the secondary controller |
| priDreq | output | 4 | Requests to the primary controller (bit 0 is the cascade) |
| priDack | input | 4 | Acknowledges from the primary controller |

## Verification
Configuration results (progWr, its fields and cfgErr) are registered, so they are due exactly one clock edge after the cycle that holds cfgWr. The bench drives each write on a falling edge and drops it on the next falling edge, and it compares the outputs there, one rising edge later. Request and acknowledge routing is combinational. Those checks change inputs on a falling edge and sample a nanosecond later, inside the same low phase, once a prior configuration has set the enables. The effect of a rejected write on the enables is observed through the forwarding paths afterwards.

// File: rtl/dmaRoutePkg.sv
package dmaRoutePkg;
  parameter int LOCAL_CH = 4;
  parameter int COUNT_W  = 16;

  localparam int SYS_CH  = 2 * LOCAL_CH;
  localparam int CH_W    = $clog2(SYS_CH);
  localparam int LOC_W   = CH_W - 1;
  localparam int BYTES_W = COUNT_W + 2;
  localparam int CASCADE = LOCAL_CH;

  typedef struct packed {
    logic accept;    // write passes every rule
    logic reject;    // write fails a rule
    logic dropChan;  // rejected write on a real channel: disable it
    logic wide;      // target is a 16-bit channel
  } ctlStrobes_t;
endpackage

// File: rtl/dmaRouteCtl.sv
module dmaRouteCtl
  import dmaRoutePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [CH_W-1:0]    cfgChan,
  input  logic [BYTES_W-1:0] cfgBytes,
  output ctlStrobes_t        strb
);
  localparam logic [BYTES_W-1:0] NARROW_MAX = BYTES_W'(1) << COUNT_W;
  localparam logic [BYTES_W-1:0] WIDE_MAX   = BYTES_W'(1) << (COUNT_W + 1);
  localparam logic [CH_W-1:0]    CASC_CH    = CH_W'(CASCADE);

  logic isCascade, isWide, oddWide, zeroLen, tooBig, badCfg;

  always_comb begin
    isCascade = (cfgChan == CASC_CH);
    isWide    = cfgChan[CH_W-1] && !isCascade;
    oddWide   = isWide && cfgBytes[0];
    zeroLen   = (cfgBytes == '0);
    tooBig    = isWide ? (cfgBytes > WIDE_MAX) : (cfgBytes > NARROW_MAX);
    badCfg    = isCascade || oddWide || zeroLen || tooBig;

    strb.accept   = cfgWr && !badCfg;
    strb.reject   = cfgWr && badCfg;
    strb.dropChan = cfgWr && badCfg && !isCascade;
    strb.wide     = isWide;
  end

  // R1
  cascade_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgChan == CASC_CH) |-> (strb.reject && !strb.accept && !strb.dropChan));

  // R4
  odd_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgChan > CASC_CH && cfgBytes[0]) |-> !strb.accept);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgBytes == '0) |-> strb.reject);
endmodule

// File: rtl/dmaRouteDp.sv
module dmaRouteDp
  import dmaRoutePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [CH_W-1:0]      cfgChan,
  input  logic [COUNT_W:0]     cfgBytesLo,
  output logic                 progWr,
  output logic                 progCtrl,
  output logic [LOC_W-1:0]     progLocal,
  output logic [COUNT_W-1:0]   progCount,
  output logic [1:0]           progStep,
  output logic                 cfgErr,
  input  logic [SYS_CH-1:0]    sysReq,
  output logic [SYS_CH-1:0]    sysAck,
  output logic [LOCAL_CH-1:0]  secDreq,
  input  logic [LOCAL_CH-1:0]  secDack,
  input  logic                 secHoldReq,
  output logic                 secHoldAck,
  output logic [LOCAL_CH-1:0]  priDreq,
  input  logic [LOCAL_CH-1:0]  priDack
);
  logic [SYS_CH-1:0]  chanEn;
  logic [COUNT_W-1:0] cycM1;

  // Word channels count bus cycles of two bytes each.
  always_comb begin
    if (strb.wide) cycM1 = cfgBytesLo[COUNT_W:1] - COUNT_W'(1);
    else           cycM1 = cfgBytesLo[COUNT_W-1:0] - COUNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEn    <= '0;
      progWr    <= 1'b0;
      progCtrl  <= 1'b0;
      progLocal <= '0;
      progCount <= '0;
      progStep  <= 2'd0;
      cfgErr    <= 1'b0;
    end else begin
      progWr <= strb.accept;
      if (strb.accept) begin
        chanEn[cfgChan] <= 1'b1;
        progCtrl        <= strb.wide;
        progLocal       <= cfgChan[LOC_W-1:0];
        progCount       <= cycM1;
        progStep        <= strb.wide ? 2'd2 : 2'd1;
        cfgErr          <= 1'b0;
      end else if (strb.reject) begin
        cfgErr <= 1'b1;
        if (strb.dropChan) chanEn[cfgChan] <= 1'b0;
      end
    end
  end

  assign secHoldAck = priDack[0];

  for (genvar k = 0; k < LOCAL_CH; k++) begin : g_route
    assign secDreq[k] = sysReq[k] & chanEn[k];
    assign sysAck[k]  = secDack[k] & priDack[0] & chanEn[k];
    if (k == 0) begin : g_casc
      assign priDreq[k]           = secHoldReq;
      assign sysAck[LOCAL_CH + k] = 1'b0;
    end else begin : g_high
      assign priDreq[k]           = sysReq[LOCAL_CH + k] & chanEn[LOCAL_CH + k];
      assign sysAck[LOCAL_CH + k] = priDack[k] & chanEn[LOCAL_CH + k];
    end
  end

  // R8
  low_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|sysAck[LOCAL_CH-1:0]) |-> priDack[0]);

  // R1
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> (cfgErr && !progWr));

  // R11
  hold_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.accept || strb.reject) |=> $stable(cfgErr));

  // R3
  wide_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && strb.wide) |=> (progWr && progCtrl && progStep == 2'd2));

  // R7
  cascade_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (priDreq[0] == secHoldReq) && (secHoldAck == priDack[0]));
endmodule

// File: rtl/dmaCascadeRouter.sv
module dmaCascadeRouter
  import dmaRoutePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [CH_W-1:0]     cfgChan,
  input  logic [BYTES_W-1:0]  cfgBytes,
  output logic                progWr,
  output logic                progCtrl,
  output logic [LOC_W-1:0]    progLocal,
  output logic [COUNT_W-1:0]  progCount,
  output logic [1:0]          progStep,
  output logic                cfgErr,
  input  logic [SYS_CH-1:0]   sysReq,
  output logic [SYS_CH-1:0]   sysAck,
  output logic [LOCAL_CH-1:0] secDreq,
  input  logic [LOCAL_CH-1:0] secDack,
  input  logic                secHoldReq,
  output logic                secHoldAck,
  output logic [LOCAL_CH-1:0] priDreq,
  input  logic [LOCAL_CH-1:0] priDack
);
  ctlStrobes_t strb;

  dmaRouteCtl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .cfgChan  (cfgChan),
    .cfgBytes (cfgBytes),
    .strb     (strb)
  );

  dmaRouteDp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgChan    (cfgChan),
    .cfgBytesLo (cfgBytes[COUNT_W:0]),
    .progWr     (progWr),
    .progCtrl   (progCtrl),
    .progLocal  (progLocal),
    .progCount  (progCount),
    .progStep   (progStep),
    .cfgErr     (cfgErr),
    .sysReq     (sysReq),
    .sysAck     (sysAck),
    .secDreq    (secDreq),
    .secDack    (secDack),
    .secHoldReq (secHoldReq),
    .secHoldAck (secHoldAck),
    .priDreq    (priDreq),
    .priDack    (priDack)
  );
endmodule

// File: tb/dmaCascadeRouter_tb.sv
module dmaCascadeRouter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWr;
  logic [2:0]  cfgChan;
  logic [17:0] cfgBytes;
  logic        progWr, progCtrl, cfgErr, secHoldAck, secHoldReq;
  logic [1:0]  progLocal, progStep;
  logic [15:0] progCount;
  logic [7:0]  sysReq, sysAck;
  logic [3:0]  secDreq, secDack, priDreq, priDack;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmaCascadeRouter dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgChan(cfgChan), .cfgBytes(cfgBytes),
    .progWr(progWr), .progCtrl(progCtrl), .progLocal(progLocal), .progCount(progCount),
    .progStep(progStep), .cfgErr(cfgErr), .sysReq(sysReq), .sysAck(sysAck),
    .secDreq(secDreq), .secDack(secDack), .secHoldReq(secHoldReq),
    .secHoldAck(secHoldAck), .priDreq(priDreq), .priDack(priDack)
  );

  // {chan[3], bytes[18], err, ctrl, local[2], count[16], step[2]} = 43 bits
  localparam int NV = 11;
  localparam logic [42:0] VECS [0:NV-1] = '{
    {3'd0, 18'd1,      1'b0, 1'b0, 2'd0, 16'h0000, 2'd1},  // R2
    {3'd3, 18'd65536,  1'b0, 1'b0, 2'd3, 16'hFFFF, 2'd1},  // R5 narrow max
    {3'd2, 18'd65537,  1'b1, 1'b0, 2'd0, 16'h0000, 2'd0},  // R5 narrow over
    {3'd1, 18'd0,      1'b1, 1'b0, 2'd0, 16'h0000, 2'd0},  // R5 zero
    {3'd4, 18'd16,     1'b1, 1'b0, 2'd0, 16'h0000, 2'd0},  // R1 cascade
    {3'd5, 18'd2,      1'b0, 1'b1, 2'd1, 16'h0000, 2'd2},  // R3
    {3'd7, 18'd131072, 1'b0, 1'b1, 2'd3, 16'hFFFF, 2'd2},  // R5 wide max
    {3'd6, 18'd131074, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0},  // R5 wide over
    {3'd6, 18'd7,      1'b1, 1'b0, 2'd0, 16'h0000, 2'd0},  // R4 odd
    {3'd6, 18'd1000,   1'b0, 1'b1, 2'd2, 16'd499,  2'd2},  // R3
    {3'd1, 18'd300,    1'b0, 1'b0, 2'd1, 16'd299,  2'd1}   // R2
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive a write on a falling edge, drop it on the next; results are then due.
  task automatic cfgWrite(input logic [2:0] ch, input logic [17:0] by);
    @(negedge clk);
    cfgWr = 1'b1; cfgChan = ch; cfgBytes = by;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic route(input logic [7:0] rq, input logic hr,
                       input logic [3:0] sd, input logic [3:0] pd);
    @(negedge clk);
    sysReq = rq; secHoldReq = hr; secDack = sd; priDack = pd;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWr = 1'b0; cfgChan = '0; cfgBytes = '0;
    sysReq = '0; secDack = '0; secHoldReq = 1'b0; priDack = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(progWr == 0 && cfgErr == 0, "R10", "reset flags", {progWr, cfgErr}, 0);
    rstN = 1'b1;
    route(8'hFF, 1'b0, 4'h0, 4'h0);
    check(secDreq == 0 && priDreq == 0, "R10", "nothing enabled", {priDreq, secDreq}, 0);
    route(8'h00, 1'b0, 4'h0, 4'h0);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VECS[i];
      cfgWrite(v[42:40], v[39:22]);
      if (v[21]) begin
        check(cfgErr == 1 && progWr == 0, "R1/R4/R5", $sformatf("reject vec %0d", i),
              {progWr, cfgErr}, 32'h1);
      end else begin
        check(cfgErr == 0 && progWr == 1, "R2/R3", $sformatf("accept vec %0d", i),
              {progWr, cfgErr}, 32'h2);
        check(progCtrl == v[20] && progLocal == v[19:18], "R2/R3",
              $sformatf("target vec %0d", i), {progCtrl, progLocal}, v[20:18]);
        check(progCount == v[17:2], "R5", $sformatf("count vec %0d", i), progCount, v[17:2]);
        check(progStep == v[1:0], "R3", $sformatf("step vec %0d", i), progStep, v[1:0]);
      end
    end

    // Enabled now: 0,1,3,5,6,7. Channel 2 was rejected, so it stays off.
    route(8'hFF, 1'b0, 4'h0, 4'h0);
    check(secDreq == 4'b1011, "R6", "low forwarding", secDreq, 4'b1011);
    check(priDreq == 4'b1110, "R6", "high forwarding", priDreq, 4'b1110);
    route(8'h10, 1'b0, 4'h0, 4'h0);
    check(priDreq == 0 && secDreq == 0, "R1", "cascade request blocked", {priDreq, secDreq}, 0);
    route(8'h00, 1'b1, 4'h0, 4'h1);
    check(priDreq == 4'b0001 && secHoldAck == 1, "R7", "cascade pass", {priDreq, secHoldAck}, 5'b00011);
    route(8'h00, 1'b1, 4'hF, 4'h0);
    check(sysAck == 0, "R8", "low ack without cascade grant", sysAck, 0);
    route(8'h00, 1'b1, 4'hF, 4'h1);
    check(sysAck == 8'h0B, "R8", "low ack with cascade grant", sysAck, 8'h0B);
    route(8'h00, 1'b0, 4'h0, 4'hF);
    check(sysAck == 8'hE0, "R9", "high acks and no ack on channel 4", sysAck, 8'hE0);

    // R4: odd count disables an enabled word channel
    route(8'h00, 1'b0, 4'h0, 4'h0);
    cfgWrite(3'd6, 18'd9);
    check(cfgErr == 1, "R4", "odd wide error", cfgErr, 1);
    route(8'h40, 1'b0, 4'h0, 4'h0);
    check(priDreq == 0, "R4", "channel 6 disabled", priDreq, 0);

    // R1: write to channel 4 leaves channel 5 enabled
    cfgWrite(3'd5, 18'd4);
    cfgWrite(3'd4, 18'd4);
    check(cfgErr == 1 && progWr == 0, "R1", "cascade write rejected", {progWr, cfgErr}, 1);
    route(8'h20, 1'b0, 4'h0, 4'h0);
    check(priDreq == 4'b0010, "R1", "enables unchanged", priDreq, 4'b0010);

    // R11: error holds over idle cycles
    repeat (3) @(negedge clk);
    check(cfgErr == 1, "R11", "error held while idle", cfgErr, 1);

    // R10: reset in mid-run clears enables and the error flag
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    route(8'hFF, 1'b0, 4'h0, 4'h0);
    check(secDreq == 0 && priDreq == 0 && cfgErr == 0, "R10", "reset mid-run",
          {cfgErr, priDreq, secDreq}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule